// File: doc/BRIEF.md
# Local Bus Region-Decoding Cycle Controller

This block turns a single-beat target request (address, byte enables, direction, write data and a one-clock start strobe) into one timed access on a simple peripheral local bus. It decodes the request offset into one of four select regions and walks a fixed phase sequence: address setup, strobe, then hold. Each phase has its own programmable length. When the cycle ends, the block returns read data and a one-clock done pulse.

One phase engine serves two strobe conventions, chosen by a configuration input. In the first, the four select lines are chip selects that stay low for the whole cycle, with separate active-low read and write strobes. In the second, the select lines act as data strobes that pulse only in the strobe phase, the write pin carries a read-not-write level, and the read pin is released to high impedance. A data-direction output steers external transceivers. The data path is either 8 bits wide with four fixed 1 KB regions, or 32 bits wide with a configurable total space and region count.

Top module: `lbus_cycle_ctrl`

## Requirements
- R1: During reset and while no cycle is running, all select outputs, the write pin and the read pin are high, the direction output and done are low, and the address and data outputs are zero.
- R2: An accepted cycle holds SETUP, STROBE and HOLD for the configured counts of clocks (a count of 0 counts as 1). done goes high for exactly one clock, in the clock right after the last HOLD clock.
- R3: In 8-bit mode (cfg_wide_i=0), offset bits [11:10] pick the region (0x000-0x3FC is region 0 and 0xC00-0xFFC is region 3). Any offset of 0x1000 or above misses. Offset bits [9:2] appear on lb_addr_o[7:0], and only data byte 0 is used.
- R4: In 32-bit mode, cfg_blk_i=00 gives 4 KB total and cfg_blk_i=01 gives 16 KB total. For 4 KB, cfg_dec_i 1000, 0111 and 0110 give 4, 2 and 1 equal regions. For 16 KB, cfg_dec_i 1000, 1001 and 1010 give 4, 2 and 1 equal regions. Offset bits [13:2] appear on lb_addr_o[11:0]. Offsets beyond the total space miss, and so does every other code pair.
- R5: In Intel signalling (cfg_moto_i=0), the selected lb_sel_no bit is low for SETUP, STROBE and HOLD. lb_wr_no is low only during STROBE of a write, lb_rd_no is low only during STROBE of a read, and lb_rd_oe_o is 1.
- R6: In Motorola signalling (cfg_moto_i=1), the selected lb_sel_no bit is low only during STROBE. lb_wr_no is 0 for a write and 1 for a read from SETUP through HOLD. lb_rd_oe_o is 0 and lb_rd_no stays high. lb_addr_o[11:8] is zero.
- R7: At most one select output is low at any time.
- R8: lb_doe_o is high from SETUP through HOLD of a write that hits a region, and low otherwise.
- R9: Read data is sampled from lb_din_i on the last STROBE clock and is zero-extended from byte 0 in 8-bit mode. A missing request asserts no select and no strobe, and a missing read returns all ones. A write leaves req_rdata_o unchanged.
- R10: A start that arrives while a cycle is running is ignored. The running cycle is unaffected, and no extra cycle follows.
- R11: In 32-bit mode, lb_be_no carries the inverted request byte enables from SETUP through HOLD of a hit. In all other cases it is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_moto_i | input | 1 | 1: Motorola signalling, 0: Intel signalling |
| cfg_wide_i | input | 1 | 1: 32-bit data mode, 0: 8-bit |
| cfg_blk_i | input | 2 | 32-bit total space code |
| cfg_dec_i | input | 4 | 32-bit region-count code |
| cfg_t_setup_i | input | 4 | SETUP length in clocks |
| cfg_t_strobe_i | input | 4 | STROBE length in clocks |
| cfg_t_hold_i | input | 4 | HOLD length in clocks |
| req_start_i | input | 1 | One-clock request strobe |
| req_addr_i | input | 16 | Request byte offset |
| req_be_i | input | 4 | Request byte enables, active high |
| req_we_i | input | 1 | 1: write, 0: read |
| req_wdata_i | input | 32 | Write data |
| req_rdata_o | output | 32 | Read data of the last read |
| req_done_o | output | 1 | One-clock completion pulse |
| lb_addr_o | output | 12 | Local address |
| lb_dout_o | output | 32 | Local write data |
| lb_din_i | input | 32 | Local read data |
| lb_doe_o | output | 1 | Data direction, 1 = outward |
| lb_sel_no | output | 4 | Chip selects or data strobes, active low |
| lb_wr_no | output | 1 | Write strobe or read-not-write level |
| lb_rd_no | output | 1 | Read strobe, active low |
| lb_rd_oe_o | output | 1 | Output enable of the read pin, 0 = high impedance |
| lb_be_no | output | 4 | Byte lanes, active low |

## Verification
The assertions check on every clock that at most one select is low, that the bus is quiet outside a cycle, that the write and read strobes are never low together, that the direction output never overlaps a read strobe, that Motorola signalling keeps the read pin released, that done lasts one clock and that the local address holds steady through a cycle. Only the bench scenarios can show the cycle-level results. These are the phase lengths per configuration, the region picked at each boundary offset and for each size and count code, misses on out-of-range offsets and unsupported codes, the captured read data, and a second start during a busy cycle being dropped.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;
  localparam int NUM_REG = 4;
  localparam int REG_W   = $clog2(NUM_REG);
endpackage

// File: rtl/lbc_region_dec.sv
module lbc_region_dec #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       wide_i,
  input  logic [1:0]                 blk_i,
  input  logic [3:0]                 dec_i,
  output logic                       hit_o,
  output logic [lbc_pkg::REG_W-1:0]  region_o
);
  int  tot_sh;
  int  reg_log;
  logic ok;

  always_comb begin
    tot_sh  = 12;
    reg_log = 2;
    ok      = 1'b1;
    if (wide_i) begin
      unique case (blk_i)
        2'b00: begin
          tot_sh = 12;
          case (dec_i)
            4'b1000: reg_log = 2;
            4'b0111: reg_log = 1;
            4'b0110: reg_log = 0;
            default: ok = 1'b0;
          endcase
        end
        2'b01: begin
          tot_sh = 14;
          case (dec_i)
            4'b1000: reg_log = 2;
            4'b1001: reg_log = 1;
            4'b1010: reg_log = 0;
            default: ok = 1'b0;
          endcase
        end
        default: ok = 1'b0;
      endcase
    end
    hit_o    = ok && ((addr_i >> tot_sh) == '0);
    region_o = lbc_pkg::REG_W'((32'(addr_i) >> (tot_sh - reg_log)) & ((32'd1 << reg_log) - 32'd1));
  end
endmodule

// File: rtl/lbc_phase_seq.sv
module lbc_phase_seq #(
  parameter int CNT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CNT_W-1:0]   t_setup_i,
  input  logic [CNT_W-1:0]   t_strobe_i,
  input  logic [CNT_W-1:0]   t_hold_i,
  output lbc_pkg::phase_e    phase_o,
  output logic               accept_o,
  output logic               last_o,
  output logic               done_o
);
  import lbc_pkg::*;

  phase_e          phase_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] ld(input logic [CNT_W-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  assign accept_o = start_i && (phase_q == PH_IDLE);
  assign last_o   = (cnt_q == '0);
  assign phase_o  = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= (phase_q == PH_HOLD) && last_o;
      unique case (phase_q)
        PH_IDLE: if (accept_o) begin
          phase_q <= PH_SETUP;
          cnt_q   <= ld(t_setup_i);
        end
        PH_SETUP: if (last_o) begin
          phase_q <= PH_STROBE;
          cnt_q   <= ld(t_strobe_i);
        end else cnt_q <= cnt_q - 1'b1;
        PH_STROBE: if (last_o) begin
          phase_q <= PH_HOLD;
          cnt_q   <= ld(t_hold_i);
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (last_o) phase_q <= PH_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lbc_pin_mux.sv
module lbc_pin_mux #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LB_AW  = 12
) (
  input  lbc_pkg::phase_e            phase_i,
  input  logic                       hit_i,
  input  logic [lbc_pkg::REG_W-1:0]  region_i,
  input  logic                       we_i,
  input  logic [DATA_W/8-1:0]        be_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       moto_i,
  input  logic                       wide_i,
  output logic [LB_AW-1:0]           lb_addr_o,
  output logic [DATA_W-1:0]          lb_dout_o,
  output logic                       lb_doe_o,
  output logic [lbc_pkg::NUM_REG-1:0] lb_sel_no,
  output logic                       lb_wr_no,
  output logic                       lb_rd_no,
  output logic                       lb_rd_oe_o,
  output logic [DATA_W/8-1:0]        lb_be_no
);
  import lbc_pkg::*;
  localparam int NARROW_AW = 8;

  logic act, stb;
  assign act = (phase_i != PH_IDLE) && hit_i;
  assign stb = (phase_i == PH_STROBE);

  always_comb begin
    lb_sel_no  = '1;
    lb_wr_no   = 1'b1;
    lb_rd_no   = 1'b1;
    lb_rd_oe_o = !moto_i;
    lb_doe_o   = 1'b0;
    lb_addr_o  = '0;
    lb_dout_o  = '0;
    lb_be_no   = '1;
    if (act) begin
      if (!moto_i) begin
        lb_sel_no[region_i] = 1'b0;
        if (stb) begin
          lb_wr_no = !we_i;
          lb_rd_no = we_i;
        end
      end else begin
        if (stb) lb_sel_no[region_i] = 1'b0;
        lb_wr_no = !we_i;
      end
      lb_doe_o  = we_i;
      lb_addr_o = wide_i ? addr_i[LB_AW+1:2] : LB_AW'(addr_i[NARROW_AW+1:2]);
      if (moto_i) lb_addr_o[LB_AW-1:NARROW_AW] = '0;  // 8 address lines only
      if (we_i) lb_dout_o = wide_i ? wdata_i : DATA_W'(wdata_i[7:0]);
      if (wide_i) lb_be_no = ~be_i;
    end
  end
endmodule

// File: rtl/lbus_cycle_ctrl.sv
module lbus_cycle_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LB_AW  = 12,
  parameter int CNT_W  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_moto_i,
  input  logic                 cfg_wide_i,
  input  logic [1:0]           cfg_blk_i,
  input  logic [3:0]           cfg_dec_i,
  input  logic [CNT_W-1:0]     cfg_t_setup_i,
  input  logic [CNT_W-1:0]     cfg_t_strobe_i,
  input  logic [CNT_W-1:0]     cfg_t_hold_i,
  input  logic                 req_start_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [DATA_W/8-1:0]  req_be_i,
  input  logic                 req_we_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  output logic [DATA_W-1:0]    req_rdata_o,
  output logic                 req_done_o,
  output logic [LB_AW-1:0]     lb_addr_o,
  output logic [DATA_W-1:0]    lb_dout_o,
  input  logic [DATA_W-1:0]    lb_din_i,
  output logic                 lb_doe_o,
  output logic [3:0]           lb_sel_no,
  output logic                 lb_wr_no,
  output logic                 lb_rd_no,
  output logic                 lb_rd_oe_o,
  output logic [DATA_W/8-1:0]  lb_be_no
);
  import lbc_pkg::*;

  phase_e               phase;
  logic                 accept, last;
  logic                 dec_hit;
  logic [REG_W-1:0]     dec_region;
  logic                 cyc_active;

  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [DATA_W/8-1:0]  be_q;
  logic                 we_q, hit_q;
  logic [REG_W-1:0]     region_q;

  lbc_region_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(req_addr_i), .wide_i(cfg_wide_i), .blk_i(cfg_blk_i), .dec_i(cfg_dec_i),
    .hit_o(dec_hit), .region_o(dec_region)
  );

  lbc_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .start_i(req_start_i),
    .t_setup_i(cfg_t_setup_i), .t_strobe_i(cfg_t_strobe_i), .t_hold_i(cfg_t_hold_i),
    .phase_o(phase), .accept_o(accept), .last_o(last), .done_o(req_done_o)
  );

  assign cyc_active = (phase != PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      be_q     <= '0;
      we_q     <= 1'b0;
      hit_q    <= 1'b0;
      region_q <= '0;
    end else if (accept) begin
      addr_q   <= req_addr_i;
      wdata_q  <= req_wdata_i;
      be_q     <= req_be_i;
      we_q     <= req_we_i;
      hit_q    <= dec_hit;
      region_q <= dec_region;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_rdata_o <= '0;
    else if (phase == PH_STROBE && last && !we_q) begin
      if (!hit_q)          req_rdata_o <= '1;
      else if (cfg_wide_i) req_rdata_o <= lb_din_i;
      else                 req_rdata_o <= DATA_W'(lb_din_i[7:0]);
    end
  end

  lbc_pin_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LB_AW(LB_AW)) u_mux (
    .phase_i(phase), .hit_i(hit_q), .region_i(region_q), .we_i(we_q), .be_i(be_q),
    .wdata_i(wdata_q), .addr_i(addr_q), .moto_i(cfg_moto_i), .wide_i(cfg_wide_i),
    .lb_addr_o, .lb_dout_o, .lb_doe_o, .lb_sel_no, .lb_wr_no, .lb_rd_no,
    .lb_rd_oe_o, .lb_be_no
  );
endmodule

// File: rtl/lbc_checker.sv
module lbc_checker #(
  parameter int LB_AW = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             active_i,
  input logic             cfg_moto_i,
  input logic [3:0]       lb_sel_no,
  input logic             lb_wr_no,
  input logic             lb_rd_no,
  input logic             lb_rd_oe_o,
  input logic             lb_doe_o,
  input logic [LB_AW-1:0] lb_addr_o,
  input logic             req_done_o
);
  assert_one_select_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~lb_sel_no));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (&lb_sel_no) && lb_wr_no && lb_rd_no && !lb_doe_o);

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |=> !req_done_o);

  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!lb_wr_no && !lb_rd_no));

  assert_doe_no_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_doe_o |-> lb_rd_no);

  assert_moto_rd_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_moto_i |-> !lb_rd_oe_o && lb_rd_no);

  assert_addr_steady_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && $past(active_i) |-> $stable(lb_addr_o));
endmodule

bind lbus_cycle_ctrl lbc_checker #(.LB_AW(LB_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .active_i(cyc_active), .cfg_moto_i(cfg_moto_i),
  .lb_sel_no(lb_sel_no), .lb_wr_no(lb_wr_no), .lb_rd_no(lb_rd_no),
  .lb_rd_oe_o(lb_rd_oe_o), .lb_doe_o(lb_doe_o), .lb_addr_o(lb_addr_o),
  .req_done_o(req_done_o)
);

// File: tb/lbus_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module lbus_cycle_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        moto = 0, wide = 0;
  logic [1:0]  blk = 0;
  logic [3:0]  dec = 4'b1000;
  logic [3:0]  ts = 1, tt = 1, th = 1;
  logic        start = 0, we = 0;
  logic [15:0] addr = 0;
  logic [3:0]  be = 0;
  logic [31:0] wdata = 0, din = 0;
  logic [31:0] rdata, dout;
  logic        done, doe, wr_n, rd_n, rd_oe;
  logic [11:0] lba;
  logic [3:0]  sel_n, be_n;

  lbus_cycle_ctrl u_lbus_cycle_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_moto_i(moto), .cfg_wide_i(wide), .cfg_blk_i(blk),
    .cfg_dec_i(dec), .cfg_t_setup_i(ts), .cfg_t_strobe_i(tt), .cfg_t_hold_i(th),
    .req_start_i(start), .req_addr_i(addr), .req_be_i(be), .req_we_i(we),
    .req_wdata_i(wdata), .req_rdata_o(rdata), .req_done_o(done), .lb_addr_o(lba),
    .lb_dout_o(dout), .lb_din_i(din), .lb_doe_o(doe), .lb_sel_no(sel_n),
    .lb_wr_no(wr_n), .lb_rd_no(rd_n), .lb_rd_oe_o(rd_oe), .lb_be_no(be_n)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] exp_rd = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [3:0] t);
    return (t == 0) ? 1 : int'(t);
  endfunction

  // Independent region model from the size and count tables
  task automatic model(input logic [15:0] a, output bit hit, output int rg);
    int total, cnt;
    total = 0; cnt = 0;
    if (!wide) begin total = 4096; cnt = 4; end
    else if (blk == 2'b00) begin
      if (dec == 4'b1000) cnt = 4; else if (dec == 4'b0111) cnt = 2; else if (dec == 4'b0110) cnt = 1;
      total = 4096;
    end else if (blk == 2'b01) begin
      if (dec == 4'b1000) cnt = 4; else if (dec == 4'b1001) cnt = 2; else if (dec == 4'b1010) cnt = 1;
      total = 16384;
    end
    hit = (cnt != 0) && (int'(a) < total);
    rg  = hit ? int'(a) / (total / cnt) : 0;
  endtask

  task automatic run(input logic [15:0] a, input logic w, input logic [31:0] wd,
                     input logic [3:0] b, input logic [31:0] d, input bit poke);
    bit hit; int rg, n, tot, c_sel, c_wr, c_rd, c_doe, c_be, bad_sel, bad_addr, bad_dout;
    logic [11:0] exp_a; logic [31:0] exp_do;
    model(a, hit, rg);
    tot = eff(ts) + eff(tt) + eff(th);
    exp_a = wide ? a[13:2] : {4'h0, a[9:2]};
    if (moto) exp_a[11:8] = 4'h0;
    exp_do = wide ? wd : {24'h0, wd[7:0]};
    c_sel = 0; c_wr = 0; c_rd = 0; c_doe = 0; c_be = 0; bad_sel = 0; bad_addr = 0; bad_dout = 0;
    @(negedge clk);
    addr = a; we = w; wdata = wd; be = b; din = d; start = 1;
    @(negedge clk);
    start = 0;
    n = 1;
    while (!done && n < 100) begin
      if (poke && n == 2) begin start = 1; addr = a ^ 16'h0400; we = !w; end
      if (poke && n == 3) start = 0;
      if (sel_n != 4'hF) begin
        c_sel++;
        if (!hit || sel_n != ~(4'b1 << rg)) bad_sel++;
        if (lba != exp_a) bad_addr++;
      end
      if (!wr_n) c_wr++;
      if (!rd_n) c_rd++;
      if (doe) begin c_doe++; if (dout != exp_do) bad_dout++; end
      if (be_n == ~b && wide && hit && b != 4'hF) c_be++;
      @(negedge clk);
      n++;
    end
    chk(n == tot + 1, "R2 done timing", n, tot + 1);
    chk(bad_sel == 0, "R7 select index", bad_sel, 0);
    chk(bad_addr == 0, wide ? "R4 local address" : "R3 local address", bad_addr, 0);
    if (!hit) begin
      chk(c_sel + c_wr + c_rd + c_doe == 0, "R9 miss quiet", c_sel + c_wr + c_rd, 0);
    end else if (!moto) begin
      chk(c_sel == tot, "R5 intel select span", c_sel, tot);
      chk((w ? c_wr : c_rd) == eff(tt), "R5 intel strobe span", w ? c_wr : c_rd, eff(tt));
      chk((w ? c_rd : c_wr) == 0, "R5 other strobe idle", w ? c_rd : c_wr, 0);
    end else begin
      chk(c_sel == eff(tt), "R6 moto data strobe span", c_sel, eff(tt));
      chk(c_wr == (w ? tot : 0), "R6 moto rnw level", c_wr, w ? tot : 0);
      chk(c_rd == 0 && rd_oe == 0, "R6 moto read pin released", c_rd, 0);
    end
    chk(c_doe == ((hit && w) ? tot : 0), "R8 direction span", c_doe, (hit && w) ? tot : 0);
    chk(bad_dout == 0, "R3 R4 write data lanes", bad_dout, 0);
    if (wide && hit && b != 4'hF) chk(c_be == tot, "R11 byte lanes", c_be, tot);
    if (!wide && hit && b != 4'hF) chk(c_be == 0, "R11 narrow byte lanes", c_be, 0);
    if (!w) exp_rd = !hit ? 32'hFFFF_FFFF : (wide ? d : {24'h0, d[7:0]});
    chk(rdata == exp_rd, "R9 read data", rdata, exp_rd);
    @(negedge clk);
    chk(!done, "R2 done one clock", done, 0);
    if (poke) begin
      c_sel = 0;
      repeat (tot + 4) begin @(negedge clk); if (sel_n != 4'hF || doe) c_sel++; end
      chk(c_sel == 0, "R10 busy start ignored", c_sel, 0);
    end
  endtask

  task automatic cfg(input logic m, input logic wd, input logic [1:0] bk, input logic [3:0] dc);
    moto = m; wide = wd; blk = bk; dec = dc;
  endtask

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (2) @(negedge clk);
    chk(sel_n == 4'hF && wr_n && rd_n && !doe && !done && lba == 0 && dout == 0,
        "R1 reset quiet", {sel_n, 3'b0, wr_n, 3'b0, rd_n, 3'b0, doe}, 32'hF110);
    rst_n = 1;
    @(negedge clk);
    chk(sel_n == 4'hF && !done, "R1 idle after reset", sel_n, 4'hF);

    // R3 region boundaries, 8-bit Intel
    cfg(0, 0, 0, 0); ts = 2; tt = 3; th = 1;
    run(16'h03FC, 0, 0, 4'h1, 32'h1234_56A5, 0);
    run(16'h0400, 1, 32'hDEAD_BE77, 4'h1, 0, 0);
    run(16'h0BFC, 0, 0, 4'h1, 32'h0000_0033, 0);
    run(16'h0FFC, 1, 32'h0000_0011, 4'h1, 0, 0);
    run(16'h1000, 0, 0, 4'h1, 32'h5555_5555, 0);   // R9 miss
    // R2 zero counts
    ts = 0; tt = 0; th = 0;
    run(16'h0804, 0, 0, 4'h1, 32'h0000_00C3, 0);
    // R4 size and count codes
    ts = 1; tt = 2; th = 2;
    cfg(0, 1, 2'b00, 4'b0111); run(16'h0800, 0, 0, 4'hF, 32'hCAFE_F00D, 0);
    cfg(0, 1, 2'b00, 4'b0110); run(16'h0FFC, 1, 32'h0102_0304, 4'h3, 0, 0);
    cfg(0, 1, 2'b01, 4'b1000); run(16'h3FFC, 1, 32'hA5A5_0F0F, 4'hC, 0, 0);
    cfg(0, 1, 2'b01, 4'b1001); run(16'h2000, 0, 0, 4'h5, 32'h8765_4321, 0);
    cfg(0, 1, 2'b01, 4'b1010); run(16'h4000, 0, 0, 4'hF, 32'h1111_2222, 0);  // beyond 16 KB
    cfg(0, 1, 2'b00, 4'b1010); run(16'h0100, 0, 0, 4'hF, 32'h3333_4444, 0);  // bad code
    cfg(0, 1, 2'b10, 4'b1000); run(16'h0100, 1, 32'h7, 4'hF, 0, 0);            // bad size
    // R6 Motorola
    cfg(1, 1, 2'b01, 4'b1000); run(16'h3F04, 1, 32'h0BAD_CAFE, 4'h9, 0, 0);
    run(16'h1234, 0, 0, 4'hF, 32'h600D_F00D, 0);
    cfg(1, 0, 0, 0); run(16'h0C08, 0, 0, 4'h1, 32'h0000_0099, 0);
    // R10 start during busy
    cfg(0, 0, 0, 0); ts = 2; tt = 2; th = 2;
    run(16'h0010, 1, 32'h44, 4'h1, 0, 1);
    cfg(1, 1, 2'b00, 4'b1000); run(16'h0420, 0, 0, 4'hF, 32'hFEED_0001, 1);

    // Constrained random
    for (int i = 0; i < 80; i++) begin
      logic [1:0] bk; logic [3:0] dc;
      bk = ($urandom_range(0, 9) == 0) ? 2'b11 : 2'($urandom_range(0, 1));
      case ($urandom_range(0, 3))
        0: dc = 4'b1000;
        1: dc = (bk == 2'b01) ? 4'b1001 : 4'b0111;
        2: dc = (bk == 2'b01) ? 4'b1010 : 4'b0110;
        default: dc = 4'($urandom);
      endcase
      cfg(1'($urandom), 1'($urandom), bk, dc);
      ts = 4'($urandom_range(0, 4)); tt = 4'($urandom_range(0, 4)); th = 4'($urandom_range(0, 4));
      run(16'($urandom_range(0, 20000)) & 16'hFFFC, 1'($urandom), $urandom, 4'($urandom),
          $urandom, ($urandom_range(0, 7) == 0));
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule